// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits beside the decode stage of a simple in-order pipeline and guesses the direction of each conditional branch without keeping any history. The guess is combinational from the decoded branch. A mode input picks one of three fixed policies: never taken, taken when the displacement is negative, or a fixed direction for each of four condition classes. In the sign and class policies, a hint bit from the instruction word reverses the guess.

A branch guessed taken produces a fetch redirect one cycle after decode, to the branch address plus four plus the word displacement. Each decoded branch is logged in a small in-order queue until the execute stage reports its real direction. If the real direction differs from the guess, the block raises a flush one cycle later with the address fetch must restart from. Every younger instruction, including any branch in decode that same cycle, belongs to the wrong path. The flush signal tells the pipeline to turn those instructions into no-ops, so they change no architectural state. Two counters record the accepted branches and the mispredictions.

Top module: `sbp_top`

## Requirements
- R1: With mode code 0 (never taken) or the spare code 3, pred_taken is 0 for every branch, whatever the hint bit is.
- R2: With mode code 1 (sign policy) and hint 0, a negative displacement predicts taken, and a zero or positive displacement predicts not taken.
- R3: With mode code 2 (class policy) and hint 0, the guess for condition class c is bit c of the parameter OPC_DIR. The default 4'b1010 makes classes 1 and 3 taken and classes 0 and 2 not taken.
- R4: In mode codes 1 and 2, hint = 1 reverses the guess.
- R5: pred_taken is 0 while dec_valid is 0. A branch predicted taken in a cycle drives redir_valid = 1 in the next cycle, with redir_pc = dec_pc + 4 + (sign-extended dec_disp << 2).
- R6: A branch predicted not taken that resolves taken drives flush_valid = 1 in the cycle after resolution, with flush_pc equal to its taken target. A resolution that matches the guess gives no flush.
- R7: A branch predicted taken that resolves not taken drives flush_valid = 1 in the cycle after resolution, with flush_pc = its dec_pc + 4.
- R8: When a misprediction resolves in the same cycle as a branch in decode, the decoded branch is discarded. In the next cycle flush_valid is 1 and redir_valid is 0, and the discarded branch is not counted. When the resolution is correct, the decoded branch proceeds normally.
- R9: br_count rises by one for each accepted branch and mis_count rises by one for each misprediction.
- R10: After reset, redir_valid, flush_valid, br_count and mis_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A conditional branch is in decode |
| dec_pc | input | PC_W | Address of the branch in decode |
| dec_disp | input | DISP_W | Signed word displacement |
| dec_cond | input | 2 | Condition class of the branch |
| dec_hint | input | 1 | Compiler hint bit (reverses the guess) |
| mode_sel | input | 2 | Policy: 0 never, 1 sign, 2 class, 3 as 0 |
| ex_valid | input | 1 | Oldest outstanding branch resolves |
| ex_taken | input | 1 | Its real direction |
| pred_taken | output | 1 | Combinational guess for the branch in decode |
| redir_valid | output | 1 | Fetch redirect for a taken guess |
| redir_pc | output | PC_W | Redirect address |
| flush_valid | output | 1 | Misprediction: squash younger instructions |
| flush_pc | output | PC_W | Correct refetch address |
| br_count | output | CNT_W | Accepted branches |
| mis_count | output | CNT_W | Mispredictions |

## Verification
The redirect of a newly decoded taken guess and the flush of an older misprediction can both come due at the same clock edge. The bench provokes this by holding a not-taken guess in flight, then presenting a negative-displacement branch in sign mode while the execute stage reports the older branch as taken. It judges the result by checking that the next cycle shows the flush to the older target with no redirect, and that br_count does not include the squashed branch. A second case repeats the overlap with a correct resolution and expects the redirect to go through.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    MODE_NEVER = 2'd0,
    MODE_SIGN  = 2'd1,
    MODE_CLASS = 2'd2,
    MODE_SPARE = 2'd3
  } sbp_mode_e;
endpackage

// File: rtl/sbp_policy.sv
module sbp_policy
  import sbp_pkg::*;
#(
  parameter int         DISP_W  = 16,
  parameter logic [3:0] OPC_DIR = 4'b1010
) (
  input  logic              valid,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        cond,
  input  logic              hint,
  input  sbp_mode_e         mode,
  output logic              taken
);
  logic base_guess;
  logic hint_used;

  always_comb begin
    base_guess = 1'b0;
    hint_used  = 1'b0;
    case (mode)
      MODE_SIGN: begin
        base_guess = disp[DISP_W-1];
        hint_used  = 1'b1;
      end
      MODE_CLASS: begin
        base_guess = OPC_DIR[cond];
        hint_used  = 1'b1;
      end
      default: begin
        base_guess = 1'b0;
        hint_used  = 1'b0;
      end
    endcase
    taken = valid & (base_guess ^ (hint & hint_used));
  end

  // R1: the fixed not-taken policy never guesses taken
  always_comb begin
    if (mode == MODE_NEVER || mode == MODE_SPARE)
      a_r1_never_taken: assert (!taken);
  end
endmodule

// File: rtl/sbp_target.sv
module sbp_target #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 16
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   taken_pc,
  output logic [PC_W-1:0]   seq_pc
);
  localparam int EXT_W = PC_W - DISP_W - 2;

  logic [PC_W-1:0] byte_off;

  always_comb begin
    byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    seq_pc   = pc + PC_W'(4);
    taken_pc = seq_pc + byte_off;
  end
endmodule

// File: rtl/sbp_track.sv
module sbp_track #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            push_pred,
  input  logic [PC_W-1:0] push_tgt,
  input  logic [PC_W-1:0] push_seq,
  input  logic            res_valid,
  input  logic            res_taken,
  output logic            mispredict,
  output logic            flush_valid,
  output logic [PC_W-1:0] flush_pc
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic            pred_q [DEPTH];
  logic [PC_W-1:0] tgt_q  [DEPTH];
  logic [PC_W-1:0] seq_q  [DEPTH];
  logic [AW-1:0]   wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            pop;
  logic            head_live;
  logic [PC_W-1:0] fix_pc;
  logic            flush_d;
  logic [PC_W-1:0] flush_pc_d;

  always_comb begin
    head_live  = (cnt_q != '0);
    pop        = res_valid & head_live;
    mispredict = pop & (res_taken != pred_q[rd_q]);
    fix_pc     = res_taken ? tgt_q[rd_q] : seq_q[rd_q];
    flush_d    = mispredict;
    flush_pc_d = mispredict ? fix_pc : flush_pc;
    wr_d       = wr_q;
    rd_d       = rd_q;
    cnt_d      = cnt_q;
    if (mispredict) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + AW'(1);
      if (pop)  rd_d = rd_q + AW'(1);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q        <= '0;
      rd_q        <= '0;
      cnt_q       <= '0;
      flush_valid <= 1'b0;
      flush_pc    <= '0;
    end else begin
      wr_q        <= wr_d;
      rd_q        <= rd_d;
      cnt_q       <= cnt_d;
      flush_valid <= flush_d;
      flush_pc    <= flush_pc_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push & (wr_q == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pred_q[g] <= 1'b0;
        tgt_q[g]  <= '0;
        seq_q[g]  <= '0;
      end else if (wr_en) begin
        pred_q[g] <= push_pred;
        tgt_q[g]  <= push_tgt;
        seq_q[g]  <= push_seq;
      end
    end
  end

  // R8: the queue never takes a branch it has no room for
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && !pop && cnt_q == CW'(DEPTH)));
  // R6: a resolution always has an outstanding branch to match
  a_r6_resolve_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> head_live);
  // R7: a flush is always preceded by a mispredicting resolution
  a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(res_valid));
endmodule

// File: rtl/sbp_top.sv
module sbp_top
  import sbp_pkg::*;
#(
  parameter int         PC_W    = 32,
  parameter int         DISP_W  = 16,
  parameter int         DEPTH   = 4,
  parameter int         CNT_W   = 16,
  parameter logic [3:0] OPC_DIR = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [PC_W-1:0]   dec_pc,
  input  logic [DISP_W-1:0] dec_disp,
  input  logic [1:0]        dec_cond,
  input  logic              dec_hint,
  input  logic [1:0]        mode_sel,
  input  logic              ex_valid,
  input  logic              ex_taken,
  output logic              pred_taken,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic              flush_valid,
  output logic [PC_W-1:0]   flush_pc,
  output logic [CNT_W-1:0]  br_count,
  output logic [CNT_W-1:0]  mis_count
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [PC_W-1:0]  tgt_pc, seq_pc;
  logic             mispredict;
  logic             accept;
  logic             redir_d;
  logic [PC_W-1:0]  redir_pc_d;
  logic [CNT_W-1:0] br_d, mis_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sbp_policy #(.DISP_W(DISP_W), .OPC_DIR(OPC_DIR)) u_policy (
    .valid (dec_valid),
    .disp  (dec_disp),
    .cond  (dec_cond),
    .hint  (dec_hint),
    .mode  (sbp_mode_e'(mode_sel)),
    .taken (pred_taken)
  );

  sbp_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
    .pc       (dec_pc),
    .disp     (dec_disp),
    .taken_pc (tgt_pc),
    .seq_pc   (seq_pc)
  );

  sbp_track #(.PC_W(PC_W), .DEPTH(DEPTH)) u_track (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .push        (accept),
    .push_pred   (pred_taken),
    .push_tgt    (tgt_pc),
    .push_seq    (seq_pc),
    .res_valid   (ex_valid),
    .res_taken   (ex_taken),
    .mispredict  (mispredict),
    .flush_valid (flush_valid),
    .flush_pc    (flush_pc)
  );

  always_comb begin
    accept     = dec_valid & ~mispredict;
    redir_d    = accept & pred_taken;
    redir_pc_d = redir_d ? tgt_pc : redir_pc;
    br_d       = accept ? br_count + CNT_W'(1) : br_count;
    mis_d      = mispredict ? mis_count + CNT_W'(1) : mis_count;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      br_count    <= '0;
      mis_count   <= '0;
    end else begin
      redir_valid <= redir_d;
      redir_pc    <= redir_pc_d;
      br_count    <= br_d;
      mis_count   <= mis_d;
    end
  end

  // R8: a flush and a redirect never show in the same cycle
  a_r8_flush_beats_redirect: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush_valid |-> !redir_valid);
  // R5: a redirect follows a taken guess in the previous cycle
  a_r5_redirect_after_guess: assert property (@(posedge clk) disable iff (!rst_int_n)
    redir_valid |-> $past(pred_taken));
  // R9: there are never more mispredictions than accepted branches
  a_r9_count_order: assert property (@(posedge clk) disable iff (!rst_int_n)
    mis_count <= br_count);
  // R5: no guess without a branch in decode
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dec_valid |-> !pred_taken);
endmodule

// File: tb/sbp_top_tb_top.sv
module sbp_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  cond;
    logic        hint;
    logic [15:0] disp;
    logic        act;
    logic        exp_pred;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 1'b1, 16'hFFFC, 1'b0, 1'b0},  // R1 hint ignored
    '{2'd0, 2'd1, 1'b0, 16'h0008, 1'b1, 1'b0},  // R1/R6 miss to target
    '{2'd1, 2'd0, 1'b0, 16'hFFFD, 1'b1, 1'b1},  // R2 negative
    '{2'd1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0},  // R2 zero
    '{2'd1, 2'd0, 1'b1, 16'h0005, 1'b0, 1'b1},  // R4 flip, R7 miss
    '{2'd1, 2'd0, 1'b1, 16'hFFFF, 1'b1, 1'b0},  // R4 flip, R6 miss
    '{2'd2, 2'd0, 1'b0, 16'h0010, 1'b0, 1'b0},  // R3 class 0
    '{2'd2, 2'd1, 1'b0, 16'h0010, 1'b1, 1'b1},  // R3 class 1
    '{2'd2, 2'd3, 1'b1, 16'h0020, 1'b0, 1'b0},  // R3/R4 class 3 flip
    '{2'd2, 2'd2, 1'b1, 16'h0030, 1'b0, 1'b1},  // R4 class 2 flip, R7 miss
    '{2'd3, 2'd1, 1'b1, 16'hFFF8, 1'b0, 1'b0},  // R1 spare code
    '{2'd1, 2'd0, 1'b0, 16'h8000, 1'b1, 1'b1}   // R5 extreme disp
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [31:0] dec_pc = '0;
  logic [15:0] dec_disp = '0;
  logic [1:0]  dec_cond = '0;
  logic        dec_hint = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic        ex_valid = 1'b0;
  logic        ex_taken = 1'b0;
  logic        pred_taken, redir_valid, flush_valid;
  logic [31:0] redir_pc, flush_pc;
  logic [15:0] br_count, mis_count;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  sbp_top dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_disp(dec_disp), .dec_cond(dec_cond), .dec_hint(dec_hint),
    .mode_sel(mode_sel), .ex_valid(ex_valid), .ex_taken(ex_taken),
    .pred_taken(pred_taken), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .flush_valid(flush_valid), .flush_pc(flush_pc),
    .br_count(br_count), .mis_count(mis_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt_of(input logic [31:0] pc, input logic [15:0] d);
    return pc + 32'd4 + {{14{d[15]}}, d, 2'b00};
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] pc;
    logic [31:0] exp_fix;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 redir_valid", 32'(redir_valid), 0);
    check("R10 flush_valid", 32'(flush_valid), 0);
    check("R10 br_count", 32'(br_count), 0);
    check("R10 mis_count", 32'(mis_count), 0);
    check("R5 idle pred", 32'(pred_taken), 0);

    for (int i = 0; i < NV; i++) begin
      pc = 32'h0000_1000 + 32'(i) * 32'h40;
      mode_sel = VEC[i].mode; dec_cond = VEC[i].cond; dec_hint = VEC[i].hint;
      dec_disp = VEC[i].disp; dec_pc = pc; dec_valid = 1'b1;
      #1;
      check($sformatf("R1-4 pred v%0d", i), 32'(pred_taken), 32'(VEC[i].exp_pred));
      @(negedge clk);
      dec_valid = 1'b0; ex_valid = 1'b1; ex_taken = VEC[i].act;
      #1;
      check($sformatf("R5 redir_valid v%0d", i), 32'(redir_valid), 32'(VEC[i].exp_pred));
      if (VEC[i].exp_pred)
        check($sformatf("R5 redir_pc v%0d", i), redir_pc, tgt_of(pc, VEC[i].disp));
      @(negedge clk);
      ex_valid = 1'b0;
      check($sformatf("R6 R7 flush v%0d", i), 32'(flush_valid), 32'(VEC[i].act != VEC[i].exp_pred));
      if (VEC[i].act != VEC[i].exp_pred) begin
        exp_fix = VEC[i].act ? tgt_of(pc, VEC[i].disp) : pc + 32'd4;
        check($sformatf("R6 R7 flush_pc v%0d", i), flush_pc, exp_fix);
      end
    end
    check("R9 br_count", 32'(br_count), 12);
    check("R9 mis_count", 32'(mis_count), 4);

    // R8 overlap with a misprediction
    mode_sel = 2'd0; dec_pc = 32'h0000_2000; dec_disp = 16'h0040; dec_valid = 1'b1; dec_hint = 1'b0;
    @(negedge clk);
    mode_sel = 2'd1; dec_pc = 32'h0000_3000; dec_disp = 16'hFFFE;
    ex_valid = 1'b1; ex_taken = 1'b1;
    #1;
    check("R8 young pred", 32'(pred_taken), 1);
    @(negedge clk);
    dec_valid = 1'b0; ex_valid = 1'b0;
    check("R8 flush", 32'(flush_valid), 1);
    check("R8 flush_pc", flush_pc, tgt_of(32'h0000_2000, 16'h0040));
    check("R8 no redirect", 32'(redir_valid), 0);
    check("R8 br_count", 32'(br_count), 13);
    check("R9 mis_count", 32'(mis_count), 5);
    @(negedge clk);

    // R8 overlap with a correct resolution
    mode_sel = 2'd1; dec_pc = 32'h0000_4000; dec_disp = 16'hFFF0; dec_valid = 1'b1;
    @(negedge clk);
    dec_pc = 32'h0000_5000; dec_disp = 16'hFFE0;
    ex_valid = 1'b1; ex_taken = 1'b1;
    #1;
    check("R5 redir first", redir_pc, tgt_of(32'h0000_4000, 16'hFFF0));
    @(negedge clk);
    dec_valid = 1'b0; ex_taken = 1'b1;
    check("R8 redir kept", 32'(redir_valid), 1);
    check("R8 redir_pc", redir_pc, tgt_of(32'h0000_5000, 16'hFFE0));
    check("R8 no flush", 32'(flush_valid), 0);
    @(negedge clk);
    ex_valid = 1'b0;
    check("R6 correct no flush", 32'(flush_valid), 0);
    check("R9 br_count final", 32'(br_count), 15);
    check("R9 mis_count final", 32'(mis_count), 5);
    finish_run();
  end
endmodule